// File: doc/BRIEF.md
# Wave-Aggregated Shared Atomic Unit

This unit applies atomic read-modify-write operations to a small bank of shared 32-bit counters for a whole wave of lanes at once. A request carries one target address, one operation code, a per-lane active mask and one 32-bit operand per lane. The counters sit inside the unit and can be changed only through these atomics. Each atomic returns the counter value it found, before the update, to the lane that issued it.

Two modes exist. In serial mode the unit runs one atomic per active lane through a single-issue pipe. It takes the lanes from the lowest index upward at one per cycle and holds off new requests until the last lane is done. In aggregated mode a pipelined cross-lane reduction tree first folds every active operand with the requested operation. Inactive lanes enter the tree as the identity of the operation. The lowest-indexed active lane then issues one atomic that carries the folded value. Both modes leave the same final counter value. The aggregated mode occupies the atomic pipe for one cycle instead of one cycle per lane.

Top module: `wave_atomic_unit`

## Requirements
- R1: Operation codes on `req_op_i`: 0 adds modulo 2^32, 1 ORs, 2 ANDs, 3 XORs, 4 keeps the unsigned minimum, 5 keeps the unsigned maximum, 6 counts. Each is applied to the addressed counter.
- R2: Count (code 6) ignores lane operands. In serial mode it adds 1 per active lane. In aggregated mode it adds the number of active lanes in a single atomic.
- R3: For the same starting value, mask, operands and operation, serial mode (`req_aggr_i`=0) and aggregated mode (`req_aggr_i`=1) leave the same final counter value.
- R4: In serial mode, a request with N active lanes produces exactly N responses, on the 1st through Nth clock edges after acceptance. They come in ascending lane order, one per cycle.
- R5: In aggregated mode with at least one active lane, exactly one response appears, on the log2(LANES)-th clock edge after acceptance. It names the lowest-indexed active lane.
- R6: A request with no active lane issues no atomic, produces no response and leaves the counters unchanged.
- R7: Every response returns the counter value before its own update. Successive serial responses to one address therefore see each other's updates.
- R8: `req_ready_o` is low while a request is still in flight. A request presented while it is low is dropped and changes no counter.
- R9: After reset every counter reads 0, `req_ready_o` is high and `rsp_valid_o` is low.
- R10: Operands of inactive lanes have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit can accept a request this cycle |
| req_aggr_i | input | 1 | 1 selects aggregated mode, 0 selects serial mode |
| req_op_i | input | 3 | Operation code (see R1) |
| req_addr_i | input | ADDR_W | Counter index |
| lane_active_i | input | LANES | Per-lane active flags |
| lane_data_i | input | LANES*32 | Per-lane operands, lane i at bits 32*i+31 to 32*i |
| rsp_valid_o | output | 1 | One atomic completed this cycle |
| rsp_lane_o | output | log2(LANES) | Lane that issued the atomic |
| rsp_old_o | output | 32 | Counter value before the atomic |

## Verification
The bench sweeps every operation code over empty, single-lane, sparse, alternating and full masks, runs each case in both modes on twin counters and reads both back. A tree that fed inactive lanes as zero instead of the identity would break AND and MIN. Unsigned comparison and add wrap-around are tested with operands that have the top bit set, so a signed comparator or a lost carry gives a wrong final value. The bench checks response timing cycle by cycle: a skipped or repeated serial lane, an off-by-one in tree latency or a wrong first lane shows up at once. A request driven while the unit is busy must leave its counter untouched, so a leaky ready shows up as a changed counter.

// File: rtl/wau_pkg.sv
package wau_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_OR  = 3'd1,
    OP_AND = 3'd2,
    OP_XOR = 3'd3,
    OP_MIN = 3'd4,
    OP_MAX = 3'd5,
    OP_CNT = 3'd6,
    OP_NOP = 3'd7
  } op_e;

  function automatic logic [DW-1:0] op_apply(op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      OP_ADD, OP_CNT: op_apply = a + b;
      OP_OR:          op_apply = a | b;
      OP_AND:         op_apply = a & b;
      OP_XOR:         op_apply = a ^ b;
      OP_MIN:         op_apply = (a < b) ? a : b;
      OP_MAX:         op_apply = (a > b) ? a : b;
      default:        op_apply = a;
    endcase
  endfunction

  // neutral element fed in for idle lanes
  function automatic logic [DW-1:0] op_ident(op_e op);
    case (op)
      OP_AND, OP_MIN: op_ident = '1;
      default:        op_ident = '0;
    endcase
  endfunction
endpackage

// File: rtl/wau_lane_pick.sv
module wau_lane_pick #(
  parameter int unsigned LANES = 8,
  localparam int unsigned LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] mask_i,
  output logic             any_o,
  output logic [LW-1:0]    idx_o
);
  always_comb begin
    any_o = |mask_i;
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = LW'(i);
    end
  end
endmodule

// File: rtl/wau_reduce_tree.sv
module wau_reduce_tree
  import wau_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LW = $clog2(LANES),
  localparam int unsigned ST = $clog2(LANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_v_i,
  input  op_e                       in_op_i,
  input  logic [ADDR_W-1:0]         in_addr_i,
  input  logic [LANES-1:0]          in_mask_i,
  input  logic [LW-1:0]             in_lane_i,
  input  logic [LANES-1:0][DW-1:0]  in_data_i,
  output logic                      out_v_o,
  output op_e                       out_op_o,
  output logic [ADDR_W-1:0]         out_addr_o,
  output logic [LANES-1:0]          out_mask_o,
  output logic [LW-1:0]             out_lane_o,
  output logic [DW-1:0]             out_val_o,
  output logic                      busy_o
);
  logic [ST:0] v_vec;

  for (genvar s = 0; s <= ST; s++) begin : g_lvl
    localparam int unsigned W = LANES >> s;
    logic [W-1:0][DW-1:0] val;
    logic                 v;
    op_e                  op;
    logic [ADDR_W-1:0]    addr;
    logic [LANES-1:0]     mask;
    logic [LW-1:0]        lane;

    assign v_vec[s] = v;

    if (s == 0) begin : g_in
      always_comb begin
        v    = in_v_i;
        op   = in_op_i;
        addr = in_addr_i;
        mask = in_mask_i;
        lane = in_lane_i;
        for (int i = 0; i < W; i++) begin
          if (!in_mask_i[i])          val[i] = op_ident(in_op_i);
          else if (in_op_i == OP_CNT) val[i] = DW'(1);
          else                        val[i] = in_data_i[i];
        end
      end
    end else begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v    <= 1'b0;
          op   <= OP_ADD;
          addr <= '0;
          mask <= '0;
          lane <= '0;
          val  <= '0;
        end else begin
          v    <= g_lvl[s-1].v;
          op   <= g_lvl[s-1].op;
          addr <= g_lvl[s-1].addr;
          mask <= g_lvl[s-1].mask;
          lane <= g_lvl[s-1].lane;
          for (int i = 0; i < W; i++) begin
            val[i] <= op_apply(g_lvl[s-1].op, g_lvl[s-1].val[2*i], g_lvl[s-1].val[2*i+1]);
          end
        end
      end
    end
  end

  assign out_v_o    = g_lvl[ST].v;
  assign out_op_o   = g_lvl[ST].op;
  assign out_addr_o = g_lvl[ST].addr;
  assign out_mask_o = g_lvl[ST].mask;
  assign out_lane_o = g_lvl[ST].lane;
  assign out_val_o  = g_lvl[ST].val[0];
  assign busy_o     = |v_vec[ST:1];
endmodule

// File: rtl/wau_atomic_pipe.sv
module wau_atomic_pipe
  import wau_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LW    = $clog2(LANES),
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_v_i,
  input  op_e               iss_op_i,
  input  logic [ADDR_W-1:0] iss_addr_i,
  input  logic [DW-1:0]     iss_arg_i,
  input  logic [LW-1:0]     iss_lane_i,
  output logic              rsp_v_o,
  output logic [LW-1:0]     rsp_lane_o,
  output logic [DW-1:0]     rsp_old_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] cur;

  assign cur = mem_q[iss_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rsp_v_o    <= 1'b0;
      rsp_lane_o <= '0;
      rsp_old_o  <= '0;
    end else begin
      rsp_v_o <= iss_v_i;
      if (iss_v_i) begin
        mem_q[iss_addr_i] <= op_apply(iss_op_i, cur, iss_arg_i);
        rsp_lane_o        <= iss_lane_i;
        rsp_old_o         <= cur;
      end
    end
  end
endmodule

// File: rtl/wave_atomic_unit.sv
module wave_atomic_unit
  import wau_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LW    = $clog2(LANES),
  localparam int unsigned ST    = $clog2(LANES),
  localparam int unsigned LAT_W = $clog2(ST + 2) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_aggr_i,
  input  logic [2:0]            req_op_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [LANES-1:0]      lane_active_i,
  input  logic [LANES*DW-1:0]   lane_data_i,
  output logic                  rsp_valid_o,
  output logic [LW-1:0]         rsp_lane_o,
  output logic [DW-1:0]         rsp_old_o
);
  logic [LANES-1:0][DW-1:0] lane_data;
  assign lane_data = lane_data_i;

  logic accept, agg_in_v;
  logic tr_busy;
  assign accept   = req_valid_i && req_ready_o;
  assign agg_in_v = accept && req_aggr_i;

  // first active lane of the incoming request
  logic          in_any;
  logic [LW-1:0] in_lead;
  wau_lane_pick #(.LANES(LANES)) u_pick_in (
    .mask_i(lane_active_i), .any_o(in_any), .idx_o(in_lead)
  );

  logic              tr_v;
  op_e               tr_op;
  logic [ADDR_W-1:0] tr_addr;
  logic [LANES-1:0]  tr_mask;
  logic [LW-1:0]     tr_lane;
  logic [DW-1:0]     tr_val;

  wau_reduce_tree #(.LANES(LANES), .ADDR_W(ADDR_W)) u_tree (
    .clk_i, .rst_ni,
    .in_v_i(agg_in_v), .in_op_i(op_e'(req_op_i)), .in_addr_i(req_addr_i),
    .in_mask_i(lane_active_i), .in_lane_i(in_lead), .in_data_i(lane_data),
    .out_v_o(tr_v), .out_op_o(tr_op), .out_addr_o(tr_addr), .out_mask_o(tr_mask),
    .out_lane_o(tr_lane), .out_val_o(tr_val), .busy_o(tr_busy)
  );

  // serial mode state
  logic [LANES-1:0]          pend_q;
  logic [LANES-1:0][DW-1:0]  data_q;
  op_e                       nv_op_q;
  logic [ADDR_W-1:0]         nv_addr_q;
  logic                      nv_iss;
  logic [LW-1:0]             nv_idx;

  wau_lane_pick #(.LANES(LANES)) u_pick_nv (
    .mask_i(pend_q), .any_o(nv_iss), .idx_o(nv_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      data_q    <= '0;
      nv_op_q   <= OP_ADD;
      nv_addr_q <= '0;
    end else if (accept && !req_aggr_i) begin
      pend_q    <= lane_active_i;
      data_q    <= lane_data;
      nv_op_q   <= op_e'(req_op_i);
      nv_addr_q <= req_addr_i;
    end else if (nv_iss) begin
      pend_q[nv_idx] <= 1'b0;
    end
  end

  assign req_ready_o = (pend_q == '0) && !tr_busy;

  // pipe arbitration: the ready rule keeps the two sources apart
  logic              agg_iss;
  logic              iss_v;
  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  logic [DW-1:0]     iss_arg;
  logic [LW-1:0]     iss_lane;

  assign agg_iss = tr_v && (tr_mask != '0);

  always_comb begin
    iss_v = agg_iss || nv_iss;
    if (agg_iss) begin
      iss_op   = tr_op;
      iss_addr = tr_addr;
      iss_arg  = tr_val;
      iss_lane = tr_lane;
    end else begin
      iss_op   = nv_op_q;
      iss_addr = nv_addr_q;
      iss_arg  = (nv_op_q == OP_CNT) ? DW'(1) : data_q[nv_idx];
      iss_lane = nv_idx;
    end
  end

  wau_atomic_pipe #(.LANES(LANES), .ADDR_W(ADDR_W)) u_pipe (
    .clk_i, .rst_ni,
    .iss_v_i(iss_v), .iss_op_i(iss_op), .iss_addr_i(iss_addr),
    .iss_arg_i(iss_arg), .iss_lane_i(iss_lane),
    .rsp_v_o(rsp_valid_o), .rsp_lane_o(rsp_lane_o), .rsp_old_o(rsp_old_o)
  );

  // cycles since an aggregated request entered the tree
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lat_q <= '0;
    else if (agg_in_v)       lat_q <= LAT_W'(1);
    else if (tr_v)           lat_q <= '0;
    else if (lat_q != '0)    lat_q <= lat_q + LAT_W'(1);
  end

  // R4
  one_issuer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(agg_iss && nv_iss));

  // R4
  serial_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_iss |=> $countones(pend_q) == $countones($past(pend_q)) - 1);

  // R4
  serial_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_iss |-> pend_q[nv_idx] && ((pend_q & ((LANES'(1) << nv_idx) - LANES'(1))) == '0));

  // R5
  tree_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tr_v |-> lat_q == LAT_W'(ST));

  // R5
  lead_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agg_iss |-> tr_mask[tr_lane] && ((tr_mask & ((LANES'(1) << tr_lane) - LANES'(1))) == '0));

  // R6
  empty_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_v && tr_mask == '0 && !nv_iss) |=> !rsp_valid_o);
endmodule

// File: tb/wave_atomic_unit_test.sv
module wave_atomic_unit_test;
  localparam int L  = 8;
  localparam int AW = 4;
  localparam int S  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_aggr = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [L-1:0] lane_act = '0;
  logic [L*32-1:0] lane_dat = '0;
  logic rsp_valid;
  logic [2:0] rsp_lane;
  logic [31:0] rsp_old;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem_m [16];
  logic [31:0] last_old;
  logic [31:0] seed = 32'hACE1_2357;

  always #10 clk = ~clk;

  wave_atomic_unit #(.LANES(L), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_aggr_i(req_aggr),
    .req_op_i(req_op), .req_addr_i(req_addr),
    .lane_active_i(lane_act), .lane_data_i(lane_dat),
    .rsp_valid_o(rsp_valid), .rsp_lane_o(rsp_lane), .rsp_old_o(rsp_old)
  );

  function automatic logic [31:0] m_apply(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'd0, 3'd6: return a + b;
      3'd1: return a | b;
      3'd2: return a & b;
      3'd3: return a ^ b;
      3'd4: return (a < b) ? a : b;
      3'd5: return (a > b) ? a : b;
      default: return a;
    endcase
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]} ^ 32'h9E37_79B9;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input bit aggr, input logic [2:0] op, input logic [AW-1:0] addr,
                     input logic [L-1:0] mask, input logic [L*32-1:0] data, input bit intrude);
    logic [2:0]  e_lane [L];
    logic [31:0] e_old [L];
    logic [31:0] fold, arg;
    int n = 0;
    int kmax, guard = 0;
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_aggr = aggr; req_op = op; req_addr = addr;
    lane_act = mask; lane_dat = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!aggr) begin
      for (int l = 0; l < L; l++) if (mask[l]) begin
        arg = (op == 3'd6) ? 32'd1 : data[l*32 +: 32];
        e_lane[n] = 3'(l); e_old[n] = mem_m[addr];
        mem_m[addr] = m_apply(op, mem_m[addr], arg);
        n++;
      end
    end else begin
      fold = (op == 3'd2 || op == 3'd4) ? 32'hFFFF_FFFF : 32'd0;
      for (int l = L - 1; l >= 0; l--) if (mask[l]) begin
        arg = (op == 3'd6) ? 32'd1 : data[l*32 +: 32];
        fold = m_apply(op, fold, arg);
        e_lane[0] = 3'(l);
      end
      if (mask != '0) begin
        e_old[0] = mem_m[addr];
        mem_m[addr] = m_apply(op, mem_m[addr], fold);
        n = 1;
      end
    end
    kmax = aggr ? S + 1 : n + 1;
    for (int k = 1; k <= kmax; k++) begin
      bit present;
      int j;
      @(negedge clk);
      if (intrude && k == 1) begin
        chk(req_ready == 1'b0, "R8 busy ready", 32'(req_ready), 32'd0);
        req_valid = 1'b1; req_aggr = 1'b1; req_op = 3'd0; req_addr = 4'd14;
        lane_act = '1; lane_dat = {L{32'h0000_0100}};
      end
      if (intrude && k == 2) req_valid = 1'b0;
      present = aggr ? (n == 1 && k == S) : (k <= n);
      j = aggr ? 0 : k - 1;
      if (present) begin
        chk(rsp_valid == 1'b1, aggr ? "R5 rsp valid" : "R4 rsp valid", 32'(rsp_valid), 32'd1);
        chk(rsp_lane == e_lane[j], aggr ? "R5 lead lane" : "R4 lane order", 32'(rsp_lane), 32'(e_lane[j]));
        chk(rsp_old == e_old[j], "R7 old value", rsp_old, e_old[j]);
        last_old = rsp_old;
      end else begin
        chk(rsp_valid == 1'b0, (mask == '0) ? "R6 no rsp" : (aggr ? "R5 no extra rsp" : "R4 no extra rsp"),
            32'(rsp_valid), 32'd0);
      end
    end
    chk(req_ready == 1'b1, "R8 ready after drain", 32'(req_ready), 32'd1);
  endtask

  task automatic probe(input logic [AW-1:0] addr);
    run(1'b1, 3'd1, addr, 8'h01, '0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [L-1:0] masks [6];
    logic [L*32-1:0] data;
    logic [31:0] v_ser, v_agg;
    masks[0] = 8'h00; masks[1] = 8'h01; masks[2] = 8'h80;
    masks[3] = 8'hFF; masks[4] = 8'hA5; masks[5] = 8'h5A;
    for (int i = 0; i < 16; i++) mem_m[i] = '0;

    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9 ready in reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R9 no rsp in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      probe(AW'(a));
      chk(last_old == 32'd0, "R9 counter zero", last_old, 32'd0);
    end

    // R1 R2 R3 R10 sweep: serial at even, aggregated at odd address
    for (int op = 0; op < 7; op++) begin
      logic [AW-1:0] as_, aa_;
      as_ = AW'(2 * op); aa_ = AW'(2 * op + 1);
      seed = nxt(seed);
      run(1'b0, 3'd0, as_, 8'h01, {{(L-1){32'h0}}, seed | 32'h8000_0000}, 1'b0);
      run(1'b0, 3'd0, aa_, 8'h01, {{(L-1){32'h0}}, seed | 32'h8000_0000}, 1'b0);
      for (int m = 0; m < 6; m++) begin
        for (int l = 0; l < L; l++) begin
          seed = nxt(seed);
          data[l*32 +: 32] = seed;
        end
        run(1'b0, 3'(op), as_, masks[m], data, 1'b0);
        run(1'b1, 3'(op), aa_, masks[m], data, 1'b0);
        probe(as_); v_ser = last_old;
        chk(v_ser == mem_m[as_], (op == 6) ? "R2 serial count" : "R1 R10 serial result", v_ser, mem_m[as_]);
        probe(aa_); v_agg = last_old;
        chk(v_agg == mem_m[aa_], (op == 6) ? "R2 aggregated count" : "R1 R10 aggregated result", v_agg, mem_m[aa_]);
        chk(v_ser == v_agg, "R3 modes agree", v_agg, v_ser);
      end
    end

    // R1 add wrap-around
    run(1'b0, 3'd0, 4'd15, 8'h01, {{(L-1){32'h0}}, 32'hFFFF_FFF0}, 1'b0);
    run(1'b1, 3'd0, 4'd15, 8'h03, {{(L-2){32'h0}}, 32'h0000_0010, 32'h0000_0008}, 1'b0);
    probe(4'd15);
    chk(last_old == 32'h0000_0008, "R1 add wraps", last_old, 32'h0000_0008);

    // R8 request during serial drain is dropped
    run(1'b0, 3'd0, 4'd15, 8'hFF, {L{32'h0000_0001}}, 1'b1);
    probe(4'd14);
    chk(last_old == 32'd0, "R8 dropped request", last_old, 32'd0);
    probe(4'd15);
    chk(last_old == 32'h0000_0010, "R8 serial total", last_old, 32'h0000_0010);

    // R6 empty request leaves counter alone
    run(1'b1, 3'd3, 4'd15, 8'h00, {L{32'hFFFF_FFFF}}, 1'b0);
    run(1'b0, 3'd3, 4'd15, 8'h00, {L{32'hFFFF_FFFF}}, 1'b0);
    probe(4'd15);
    chk(last_old == 32'h0000_0010, "R6 unchanged", last_old, 32'h0000_0010);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule